// File: doc/BRIEF.md
# Switching-Cycle Gate Pulse Timer

This block times the gate-drive pulse of a peak-current-mode power converter controller. A free-running counter divides the system clock into switching cycles of a programmable length. The gate output goes high at the start of every cycle. It goes low again on whichever comes first of two events. The first is a current-comparator trip that arrives after a leading-edge blanking window and after a minimum on-time. The second is a duty-cycle cap, which is a fixed percentage of the programmed period.

Two cap percentages are available: a flyback setting near half the period and a boost setting near the whole period. In the flyback setting, an external sync pulse may start cycles earlier than the programmed period would. The cap stays the same number of ticks in that case, so the effective duty ratio rises with the sync rate. The analog comparator, slope ramp and error amplifier sit outside the block, and every duration is counted in clock ticks.

Top module: `gate_pulse_timer`

## Requirements
- R1: While `en` is low, `gate` and `cyc_start` stay low. On the first clock edge that samples `en` high, a cycle starts: `gate` and `cyc_start` are high after that edge.
- R2: In free-running operation, `cyc_start` pulses for one tick every `period` ticks (`period` >= 2), and `gate` rises together with it.
- R3: With no comparator trip, the gate stays high for CAP ticks, where CAP is floor(`period`*49/100) when `boost_mode`=0 and floor(`period`*94/100) when `boost_mode`=1, with a floor of 1.
- R4: `blank_act` is high for exactly the first BLANK_TICKS (default 7) ticks of every gate pulse. A `cs_trip` level sampled during those ticks does not end the pulse.
- R5: When `cs_trip` is first sampled high at cycle tick c (c >= BLANK_TICKS) and held, the gate is high for c+TRIP_LAT+1 ticks (TRIP_LAT default 2), within the limits of R3 and R6.
- R6: A comparator trip never makes the gate pulse shorter than MIN_ON_TICKS (default 13) ticks. The duty cap of R3 still applies.
- R7: With `boost_mode`=0, a rising edge of `sync_in` sampled while the gate is low starts a new cycle at that edge, and the following pulse still lasts the same CAP ticks.
- R8: With `boost_mode`=1, `sync_in` has no effect: the cycle length stays `period` and the pulse width stays CAP.
- R9: With `boost_mode`=0, a rising edge of `sync_in` sampled while the gate is high drives the gate low after that edge, overriding the minimum on-time. A new cycle starts one tick later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the gate off and clears the cycle |
| period | input | CNT_W | Switching period in ticks (>= 2) |
| boost_mode | input | 1 | 0: flyback cap with sync accepted; 1: boost cap, sync ignored |
| sync_in | input | 1 | External sync; rising edge starts a cycle in flyback setting |
| cs_trip | input | 1 | Peak-current comparator output, active high |
| gate | output | 1 | Gate-drive output |
| cyc_start | output | 1 | One-tick strobe marking the first tick of each cycle |
| blank_act | output | 1 | High while leading-edge blanking masks the comparator |

## Verification
Pulse width and cycle length are swept over four periods, both cap settings, and a comparator level that first rises at ticks ranging from before blanking, through the blanking edge and the minimum on-time, to past the cap. Each expected width is computed from the min/max formula, so each sweep point shows which of blanking, trip latency, minimum on-time or cap set the edge. Single sync pulses placed just before the period ends and early inside a pulse separate an early cycle start from a forced cut. The same pulses in the boost setting show that sync is ignored there. Enable is dropped mid-cycle and raised again to pin down the first-cycle timing.

// File: rtl/gate_pulse_timer.sv
module gate_pulse_timer #(
  parameter int CNT_W        = 12,
  parameter int BLANK_TICKS  = 7,
  parameter int MIN_ON_TICKS = 13,
  parameter int TRIP_LAT     = 2,
  parameter int FLY_PCT      = 49,
  parameter int BOOST_PCT    = 94
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  input  logic             boost_mode,
  input  logic             sync_in,
  input  logic             cs_trip,
  output logic             gate,
  output logic             cyc_start,
  output logic             blank_act
);

  localparam int PW = CNT_W + 8;

  logic [CNT_W-1:0]    cnt;
  logic                gate_q, run_q, pend_q, trip_q, sync_q, start_q;
  logic [TRIP_LAT-1:0] pipe_q, pipe_nx;

  wire [PW-1:0] fly_prod   = PW'(period) * PW'(FLY_PCT);
  wire [PW-1:0] boost_prod = PW'(period) * PW'(BOOST_PCT);
  wire [PW-1:0] cap_raw    = (boost_mode ? boost_prod : fly_prod) / PW'(100);
  wire [CNT_W-1:0] cap_ticks = (cap_raw == '0) ? CNT_W'(1) : cap_raw[CNT_W-1:0];

  wire sync_edge = sync_in & ~sync_q & ~boost_mode & run_q;
  wire cut_sync  = sync_edge & gate_q;
  wire at_wrap   = cnt >= (period - 1'b1);
  wire start     = en & (~run_q | pend_q | at_wrap | (sync_edge & ~gate_q));
  wire cap_hit   = cnt >= (cap_ticks - 1'b1);
  wire min_met   = cnt >= CNT_W'(MIN_ON_TICKS - 1);
  wire trip_hit  = pipe_q[TRIP_LAT-1] | trip_q;
  wire qual      = gate_q & ~blank_act & cs_trip;

  assign blank_act = gate_q & (cnt < CNT_W'(BLANK_TICKS));
  assign gate      = gate_q;
  assign cyc_start = start_q;

  generate
    if (TRIP_LAT > 1) begin : g_pipe
      assign pipe_nx = {pipe_q[TRIP_LAT-2:0], qual};
    end else begin : g_one
      assign pipe_nx = qual;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; gate_q <= 1'b0; run_q <= 1'b0; pend_q <= 1'b0;
      trip_q <= 1'b0; sync_q <= 1'b0; start_q <= 1'b0; pipe_q <= '0;
    end else begin
      sync_q <= sync_in;
      if (!en) begin
        cnt <= '0; gate_q <= 1'b0; run_q <= 1'b0; pend_q <= 1'b0;
        trip_q <= 1'b0; start_q <= 1'b0; pipe_q <= '0;
      end else if (start) begin
        cnt <= '0; gate_q <= 1'b1; run_q <= 1'b1; pend_q <= 1'b0;
        trip_q <= 1'b0; start_q <= 1'b1; pipe_q <= '0;
      end else begin
        start_q <= 1'b0;
        cnt     <= cnt + 1'b1;
        pend_q  <= cut_sync;
        if (gate_q && (cut_sync || cap_hit || (trip_hit && min_met)))
          gate_q <= 1'b0;
        trip_q  <= trip_q | (gate_q & pipe_q[TRIP_LAT-1]);
        pipe_q  <= gate_q ? pipe_nx : '0;
      end
    end
  end

  p_en_low_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate && !cyc_start));

  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> gate);

  p_blank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && blank_act && en && !sync_edge && !at_wrap && (cnt + 1'b1 < cap_ticks)) |=> gate);

  p_min_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && en && !sync_edge && !at_wrap && !min_met && (cnt + 1'b1 < cap_ticks)) |=> gate);

  p_sync_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cut_sync && !at_wrap) |=> (!gate && !cyc_start));

endmodule

// File: tb/gate_pulse_timer_tb.sv
module gate_pulse_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int BLANK = 7;
  localparam int MIN_ON = 13;
  localparam int LAT = 2;

  logic clk = 0, rst_n = 0, en = 0, boost_mode = 0, sync_in = 0, cs_trip = 0;
  logic [CNT_W-1:0] period = 40;
  logic gate, cyc_start, blank_act;
  int checks = 0, failures = 0, ticks = 0;

  gate_pulse_timer #(.CNT_W(CNT_W), .BLANK_TICKS(BLANK), .MIN_ON_TICKS(MIN_ON),
    .TRIP_LAT(LAT), .FLY_PCT(49), .BOOST_PCT(94)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .boost_mode(boost_mode),
    .sync_in(sync_in), .cs_trip(cs_trip), .gate(gate), .cyc_start(cyc_start),
    .blank_act(blank_act));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000) begin
      failures++;
      $display("FAIL watchdog: act=%0d exp=<150000", ticks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_start();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (cyc_start) break;
    end
  endtask

  function automatic int cap_of(input int p, input bit b);
    int c = (p * (b ? 94 : 49)) / 100;
    return (c < 1) ? 1 : c;
  endfunction

  // Call at the negedge where cyc_start is high; returns at the next one.
  task automatic measure(input int trip_at, input int sync_at,
                         output int w, output int p, output int b);
    w = 0; p = 0; b = 0;
    do begin
      if (gate) w++;
      if (blank_act) b++;
      cs_trip = (trip_at >= 0) && (p >= trip_at);
      sync_in = (p == sync_at);
      p++;
      @(negedge clk);
    end while (!cyc_start && p < 5000);
    cs_trip = 0;
    sync_in = 0;
  endtask

  initial begin
    int w, p, b, ex, cap;
    int plist[4] = '{20, 37, 64, 100};
    int tlist[9] = '{-1, 0, 3, 6, 7, 9, 12, 15, 40};
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) begin
      @(negedge clk);
      chk("R1 reset gate", gate, 0);
      chk("R1 reset strobe", cyc_start, 0);
    end
    en = 1;
    @(negedge clk);
    chk("R1 first gate", gate, 1);
    chk("R1 first strobe", cyc_start, 1);
    repeat (5) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk("R1 drop gate", gate, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1 idle strobe", cyc_start, 0);
    end
    en = 1;
    @(negedge clk);
    chk("R1 restart strobe", cyc_start, 1);

    foreach (plist[i]) begin
      for (int m = 0; m < 2; m++) begin
        foreach (tlist[j]) begin
          wait_start();
          period = CNT_W'(plist[i]);
          boost_mode = m[0];
          measure(tlist[j], -1, w, p, b);
          cap = cap_of(plist[i], m[0]);
          if (tlist[j] < 0) ex = cap;
          else begin
            ex = ((tlist[j] > BLANK) ? tlist[j] : BLANK) + LAT + 1;
            if (ex < MIN_ON) ex = MIN_ON;
            if (ex > cap) ex = cap;
          end
          if (tlist[j] < 0 || ex == cap) tag = "R3 width";
          else if (ex == MIN_ON) tag = "R6 min on width";
          else tag = "R5 trip width";
          chk(tag, w, ex);
          chk("R2 period", p, plist[i]);
          chk("R4 blank ticks", b, (cap < BLANK) ? cap : BLANK);
        end
      end
    end

    wait_start();
    period = 40; boost_mode = 0;
    measure(-1, 29, w, p, b);
    chk("R7 sync period", p, 30);
    chk("R7 sync width", w, 19);
    measure(-1, 29, w, p, b);
    chk("R7 sync period again", p, 30);
    chk("R7 cap kept", w, 19);
    measure(40, 5, w, p, b);
    chk("R9 cut width", w, 6);
    chk("R9 cut period", p, 7);
    measure(-1, -1, w, p, b);
    chk("R9 recovery width", w, 19);
    wait_start();
    boost_mode = 1;
    measure(-1, 29, w, p, b);
    chk("R8 boost period", p, 40);
    chk("R8 boost width", w, 37);
    measure(-1, 5, w, p, b);
    chk("R8 boost no cut", w, 37);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule